// File: doc/BRIEF.md
# Stereo DAC Channel Conditioner

This block sits in front of a stereo digital-to-analogue converter. It takes one pair of signed left and right samples per accepted input beat and routes the pair through three stages in a fixed order. The first stage is a mono-mix selector. The second is a global phase inversion. The third is a ramped soft-mute gain. The processed pair leaves through a single output register that has a valid flag.

The settings arrive as plain parallel inputs: the mix mode, the invert enable, the mute enable and a two-bit de-emphasis code. The block samples all of them together with the data on each accepted beat, so every output sample was built with a single consistent set of controls. The de-emphasis code is not acted on. It is carried with the sample to `deemph_out` for a filter stage further down the chain.

Both data sides use valid/ready. A beat transfers on a rising clock edge where valid and ready are both high. The output stage holds one sample. `in_ready` is high whenever that stage is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output data and the de-emphasis code hold steady, and no new input is taken.

Top module: `dac_chan_cond`

## Requirements
- R1: With `mix_mode` = 2'b00 each output carries its own input channel unchanged (at unity gain, no inversion).
- R2: With `mix_mode` = 2'b01 the left output carries (L+R)/2 and the right output carries zero.
- R3: With `mix_mode` = 2'b10 the right output carries (L+R)/2 and the left output carries zero.
- R4: With `mix_mode` = 2'b11 both outputs carry (L+R)/2, formed as the floor of the full-precision sum shifted right by one. It never overflows, even for two full-scale inputs of the same sign.
- R5: With `invert_en` = 1 both output channels are negated. With `invert_en` = 0 they are not.
- R6: Negating the most negative sample value gives the most positive value, not a wrapped result.
- R7: Soft mute: a gain g in 0..2^RAMP_LOG2 resets to 0. Each accepted sample leaves as floor(x*g / 2^RAMP_LOG2) using the current g. After that sample, g steps by one toward 0 when `mute_en` = 1, or toward 2^RAMP_LOG2 when `mute_en` = 0, and stays clamped at the ends.
- R8: The stages apply in the order mix, then invert, then gain. For example, mode 2'b11 with two most-negative inputs and invert set yields the most positive value at unity gain.
- R9: A sample accepted on an edge appears on the outputs, with `out_valid` high, right after that edge (one register of latency).
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. While a sample is stalled (`out_valid` high, `out_ready` low), `out_left`, `out_right` and `deemph_out` hold their values.
- R11: The controls are sampled only on an accepted beat. `deemph_out` carries the 2-bit code of that beat unchanged (11 for 48 kHz, 10 for 44.1 kHz, 01 for 32 kHz, 00 for none).
- R12: After reset `out_valid` is 0, `deemph_out` is 2'b00 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can take an input pair |
| in_left | input | DATA_W | Left sample, signed |
| in_right | input | DATA_W | Right sample, signed |
| mix_mode | input | 2 | 00 stereo, 01 mono on left, 10 mono on right, 11 mono on both |
| invert_en | input | 1 | Negate both channels |
| mute_en | input | 1 | Ramp gain toward silence when 1 |
| deemph_sel | input | 2 | De-emphasis code, passed through |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream takes the output pair |
| out_left | output | DATA_W | Processed left sample, signed |
| out_right | output | DATA_W | Processed right sample, signed |
| deemph_out | output | 2 | De-emphasis code of the output sample |

## Verification
The bench keeps DATA_W at 24 so that the full-scale corners are exercised at the real width. These include the most negative value under inversion and the sum of two full-scale inputs. It builds the block with RAMP_LOG2 = 4, so that a complete ramp is 16 samples. This lets a short run cover the whole fade-in from silence, a long stretch at exact unity gain and a full fade back to zero. A repeating output-stall pattern keeps back-pressure active throughout the run.

// File: rtl/dac_cond_pkg.sv
package dac_cond_pkg;
  typedef enum logic [1:0] {
    MIX_STEREO = 2'b00,
    MIX_ON_L   = 2'b01,
    MIX_ON_R   = 2'b10,
    MIX_ON_LR  = 2'b11
  } mix_mode_e;
endpackage

// File: rtl/dac_mono_mixer.sv
module dac_mono_mixer
  import dac_cond_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic signed [DATA_W-1:0] src_l,
  input  logic signed [DATA_W-1:0] src_r,
  input  mix_mode_e                mode,
  output logic signed [DATA_W-1:0] mix_l,
  output logic signed [DATA_W-1:0] mix_r
);
  localparam int SUM_W = DATA_W + 1;

  logic signed [SUM_W-1:0] sum_full;
  logic signed [SUM_W-1:0] sum_half;
  logic signed [DATA_W-1:0] avg;

  always_comb begin
    sum_full = SUM_W'(src_l) + SUM_W'(src_r);
    sum_half = sum_full >>> 1;
    avg      = sum_half[DATA_W-1:0];
    unique case (mode)
      MIX_STEREO: begin mix_l = src_l; mix_r = src_r; end
      MIX_ON_L:   begin mix_l = avg;   mix_r = '0;    end
      MIX_ON_R:   begin mix_l = '0;    mix_r = avg;   end
      default:    begin mix_l = avg;   mix_r = avg;   end
    endcase
  end

  // The half-sum always lies between the two inputs.
  always_comb begin
    if (mode == MIX_ON_LR)
      AST_MIX_BOUNDED: assert ((mix_l >= src_l || mix_l >= src_r) &&
                               (mix_l <= src_l || mix_l <= src_r)); // R4
  end
endmodule

// File: rtl/dac_phase_inv.sv
module dac_phase_inv #(
  parameter int DATA_W = 24
) (
  input  logic                     inv,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (!inv)                  dout = din;
    else if (din == MOST_NEG)  dout = MOST_POS;
    else                       dout = -din;
  end

  always_comb begin
    if (inv)
      AST_NO_WRAP_NEG: assert (dout != MOST_NEG); // R6
  end
endmodule

// File: rtl/dac_mute_ramp.sv
module dac_mute_ramp #(
  parameter int DATA_W    = 24,
  parameter int RAMP_LOG2 = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic                     mute,
  input  logic signed [DATA_W-1:0] x_l,
  input  logic signed [DATA_W-1:0] x_r,
  output logic signed [DATA_W-1:0] y_l,
  output logic signed [DATA_W-1:0] y_r
);
  localparam int G_W  = RAMP_LOG2 + 1;
  localparam int P_W  = DATA_W + G_W + 1;
  localparam logic [G_W-1:0] UNITY = G_W'(1) << RAMP_LOG2;

  logic [G_W-1:0]        gain;
  logic signed [P_W-1:0] gain_s;
  logic signed [P_W-1:0] prod_l, prod_r, shl, shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain <= '0;
    end else if (step) begin
      if (mute && gain != '0)          gain <= gain - 1'b1;
      else if (!mute && gain != UNITY) gain <= gain + 1'b1;
    end
  end

  always_comb begin
    gain_s = $signed({{(P_W-G_W){1'b0}}, gain});
    prod_l = P_W'(x_l) * gain_s;
    prod_r = P_W'(x_r) * gain_s;
    shl    = prod_l >>> RAMP_LOG2;
    shr    = prod_r >>> RAMP_LOG2;
    y_l    = shl[DATA_W-1:0];
    y_r    = shr[DATA_W-1:0];
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= UNITY); // R7
  AST_GAIN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (int'(gain) - int'($past(gain)) <= 1) &&
             (int'($past(gain)) - int'(gain) <= 1)); // R7
  AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(gain)); // R11
endmodule

// File: rtl/dac_chan_cond.sv
module dac_chan_cond
  import dac_cond_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int RAMP_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [1:0]        mix_mode,
  input  logic              invert_en,
  input  logic              mute_en,
  input  logic [1:0]        deemph_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic [1:0]        deemph_out
);
  logic take;
  logic signed [DATA_W-1:0] mixed [2];
  logic signed [DATA_W-1:0] flipped [2];
  logic signed [DATA_W-1:0] scaled [2];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  dac_mono_mixer #(.DATA_W(DATA_W)) u_mix (
    .src_l (signed'(in_left)),
    .src_r (signed'(in_right)),
    .mode  (mix_mode_e'(mix_mode)),
    .mix_l (mixed[0]),
    .mix_r (mixed[1])
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_inv
    dac_phase_inv #(.DATA_W(DATA_W)) u_inv (
      .inv  (invert_en),
      .din  (mixed[ch]),
      .dout (flipped[ch])
    );
  end

  dac_mute_ramp #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take),
    .mute  (mute_en),
    .x_l   (flipped[0]),
    .x_r   (flipped[1]),
    .y_l   (scaled[0]),
    .y_r   (scaled[1])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_left   <= '0;
      out_right  <= '0;
      deemph_out <= 2'b00;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_left   <= scaled[0];
      out_right  <= scaled[1];
      deemph_out <= deemph_sel;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) &&
                                $stable(out_right) && $stable(deemph_out)); // R10
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
  AST_DEEMPH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> deemph_out == $past(deemph_sel)); // R11
endmodule

// File: tb/tb_dac_chan_cond.sv
module tb_dac_chan_cond;
  localparam int W  = 24;
  localparam int RL = 4;
  localparam int UNITY = 1 << RL;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [W-1:0] in_left = '0, in_right = '0, out_left, out_right;
  logic [1:0] mix_mode = 0, deemph_sel = 0, deemph_out;
  logic invert_en = 0, mute_en = 1;

  always #4 clk = ~clk;

  dac_chan_cond #(.DATA_W(W), .RAMP_LOG2(RL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .mix_mode(mix_mode),
    .invert_en(invert_en), .mute_en(mute_en), .deemph_sel(deemph_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_right(out_right), .deemph_out(deemph_out)
  );

  typedef struct { longint l; longint r; int de; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0, cyc = 0, g = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint neg_sat(longint x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  task automatic send(longint l, longint r, int mode, bit inv, bit mute, int de, string tag);
    longint a, ml, mr;
    item_t it;
    @(negedge clk);
    in_left = l[W-1:0]; in_right = r[W-1:0]; mix_mode = mode[1:0];
    invert_en = inv; mute_en = mute; deemph_sel = de[1:0]; in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    a = (l + r) >>> 1;
    case (mode)
      0: begin ml = l; mr = r; end
      1: begin ml = a; mr = 0; end
      2: begin ml = 0; mr = a; end
      default: begin ml = a; mr = a; end
    endcase
    if (inv) begin ml = neg_sat(ml); mr = neg_sat(mr); end
    it.l = (ml * g) >>> RL; it.r = (mr * g) >>> RL; it.de = de; it.tag = tag;
    sb.push_back(it);
    if (mute && g > 0) g--; else if (!mute && g < UNITY) g++;
    @(posedge clk); #1;
    in_valid = 0;
    check(out_valid === 1'b1, "R9", "out_valid after accept", out_valid, 1);
  endtask

  // monitor with scoreboard and stall pattern
  initial begin
    bit held = 0;
    logic [W-1:0] hl, hr;
    logic [1:0] hd;
    item_t e;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (held)
        check(out_left == hl && out_right == hr && deemph_out == hd, "R10",
              "stalled output held", $signed(out_left), $signed(hl));
      out_ready = (cyc % 5 != 3) && !(cyc % 97 >= 60 && cyc % 97 < 66);
      #1;
      check(in_ready == (!out_valid || out_ready), "R10", "in_ready rule",
            in_ready, (!out_valid || out_ready));
      held = out_valid && !out_ready;
      hl = out_left; hr = out_right; hd = deemph_out;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check(0, "R9", "unexpected output", 1, 0);
        else begin
          e = sb.pop_front();
          check($signed(out_left) == e.l, e.tag, "left", $signed(out_left), e.l);
          check($signed(out_right) == e.r, e.tag, "right", $signed(out_right), e.r);
          check(deemph_out == e.de[1:0], e.tag, "deemph", deemph_out, e.de);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20;
    check(out_valid === 1'b0, "R12", "out_valid in reset", out_valid, 0);
    check(deemph_out === 2'b00, "R12", "deemph in reset", deemph_out, 0);
    rst_n = 1;
    @(negedge clk); #2;
    check(in_ready === 1'b1, "R12", "in_ready after reset", in_ready, 1);
    // fade in from silence
    for (int i = 0; i < UNITY + 4; i++) send(1000 + i, -777, 0, 0, 0, 0, "R7");
    // stereo
    send(12345, -54321, 0, 0, 0, 1, "R1");
    send(MAXV, MINV, 0, 0, 0, 2, "R1");
    // mono on one side
    send(100, 301, 1, 0, 0, 3, "R2");
    send(-3, 0, 1, 0, 0, 0, "R2");
    send(100, 301, 2, 0, 0, 1, "R3");
    send(MINV, 5, 2, 0, 0, 2, "R3");
    // mono on both, no overflow
    send(MAXV, MAXV, 3, 0, 0, 3, "R4");
    send(MINV, MINV, 3, 0, 0, 0, "R4");
    send(-5, 2, 3, 0, 0, 1, "R4");
    // invert
    send(4000, -9, 0, 1, 0, 2, "R5");
    send(77, 88, 0, 0, 0, 3, "R5");
    send(MINV, MAXV, 0, 1, 0, 0, "R6");
    send(MINV, MINV, 3, 1, 0, 1, "R8");
    send(600, -200, 1, 1, 0, 2, "R8");
    // de-emphasis codes per sample
    for (int k = 0; k < 4; k++) send(k * 11, -k, 0, 0, 0, k, "R11");
    // fade out to silence and beyond
    for (int i = 0; i < UNITY + 4; i++) send(-50000 + i, 40000, 0, i % 2, 1, 3, "R7");
    send(MAXV, MINV, 3, 1, 1, 2, "R7");
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule